// File: doc/BRIEF.md
# Accumulator Computer Control Unit

This block is a small 8-bit accumulator processor with its own 256-byte store. While the processor is idle, a host port writes program and data bytes into the store. A rising edge on the start input then runs the program from the current program counter until an undefined opcode is fetched, at which point the processor drops its busy output and holds its state for inspection.

Each instruction is sequenced by a step counter whose decoded value, together with the decoded opcode, selects the register transfers of that cycle. Every instruction begins with the same two fetch steps. The execute steps differ by opcode, and clearing the step counter hands control back to fetch. The architectural registers are a program counter, an address register, a data register, an instruction register and the accumulator, plus sign, zero, overflow and carry flags. A per-opcode rule decides which flags an instruction may change.

A second, filtered reset input returns the machine to its initial state only after it has been held high for three consecutive clock edges following a low level. The store contents survive this reset.

Top module: `accu_core`

## Requirements
- R1: After the power-on reset (rstN low) or an accepted soft reset, pcOut = 0, acOut = 0, flagsOut = 0 and busy = 0.
- R2: resetReq takes effect on the third consecutive clock edge at which it is sampled high after a low sample. A pulse of two edges changes nothing, and the store keeps its contents across a soft reset.
- R3: busy rises on the clock edge that samples startIn high after a low sample while idle. Holding startIn high after a halt does not restart the program, and while idle the registers and flags stay unchanged.
- R4: Every instruction starts with two fetch cycles: the byte at PC goes to DR, then to IR, and PC increments. Including fetch, INA, CMA, JMPE and a halt take 3 cycles; LDI, ADI, SUBI, branches and JMPI take 4; STA takes 5; LDA takes 6. busy stays high for exactly the sum of these cycles.
- R5: The opcodes are INA 01 (AC+1), ADI 04 (AC+imm) and SUBI 05 (AC+~imm+1). Each of them updates all four flags: Z (result zero), S (result bit 7), C (carry out of bit 7, so for SUBI C=1 means no borrow) and V (signed overflow). flagsOut is {S,Z,V,C} from bit 3 down to bit 0.
- R6: CMA 02 (AC = ~AC) and LDI 03 (AC = imm) update only Z and S; C and V keep their values.
- R7: LDA 06 loads AC from the store at an address byte, and STA 07 writes AC to the store at an address byte. Neither changes any flag.
- R8: The branches 08 to 0F carry an absolute target byte. Opcode bits [2:1] select the flag (00 Z, 01 C, 10 S, 11 V), and bit 0 = 1 inverts the test (branch when the flag is clear). A taken branch loads PC with the target; a not-taken branch moves PC past the target byte. No branch changes any flag.
- R9: JMPI 10 always loads PC from its target byte. JMPE 11 loads PC from the extAddr input.
- R10: Any other opcode (for example 00 or FF) halts: busy falls, PC is left pointing one past the opcode byte, and AC and the flags are unchanged.
- R11: Host writes (hostWe) reach the store only while busy is 0; a write attempted while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| startIn | input | 1 | Start request, acted on at a rising level |
| resetReq | input | 1 | Filtered soft reset request |
| hostWe | input | 1 | Store write enable from the host |
| hostAddr | input | 8 | Store write address |
| hostData | input | 8 | Store write data |
| extAddr | input | 8 | External jump target for JMPE |
| busy | output | 1 | High while a program runs |
| pcOut | output | 8 | Program counter |
| acOut | output | 8 | Accumulator |
| flagsOut | output | 4 | Flags {S,Z,V,C} |

## Verification
Short programs exercise the arithmetic at carry-out, signed-overflow and zero boundaries, which separates a correct carry and overflow from an inverted or borrow-style one. A chain of ADI, CMA and LDI shows that the flag-update rule preserves C and V where it must. Every branch opcode runs after two flag preludes with opposite flag sets, so each condition is seen both taken and not taken. The busy-cycle count for each program checks the step sequencing. Separate cases cover the two-edge reset pulse against the three-edge one, a store write attempted mid-run, and a start level held high across a halt.

// File: rtl/accu_pkg.sv
package accu_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int NSTEP  = 6;
  localparam int STEP_W = $clog2(NSTEP);
  localparam int RST_HOLD = 3;

  localparam logic [7:0] OP_INA  = 8'h01;
  localparam logic [7:0] OP_CMA  = 8'h02;
  localparam logic [7:0] OP_LDI  = 8'h03;
  localparam logic [7:0] OP_ADI  = 8'h04;
  localparam logic [7:0] OP_SUBI = 8'h05;
  localparam logic [7:0] OP_LDA  = 8'h06;
  localparam logic [7:0] OP_STA  = 8'h07;
  localparam logic [7:0] OP_JMPI = 8'h10;
  localparam logic [7:0] OP_JMPE = 8'h11;

  typedef enum logic [2:0] {
    AC_HOLD, AC_INC, AC_CMP, AC_LOAD, AC_ADD, AC_SUB
  } acOp_e;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic  clrAll;
    logic  hostWrite;
    logic  drFromMem;
    logic  addrFromAr;
    logic  irLoad;
    logic  pcInc;
    logic  pcLoadDr;
    logic  pcLoadExt;
    logic  arLoad;
    logic  memStore;
    logic  updZS;
    logic  updCV;
    acOp_e acOp;
  } ctl_t;
endpackage

// File: rtl/accu_ctrl.sv
module accu_ctrl
  import accu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              resetReq,
  input  logic              hostWe,
  input  logic [7:0]        opcode,
  input  logic [3:0]        flags,   // {S,Z,V,C}
  output ctl_t              ctl,
  output logic              busy,
  output logic [STEP_W-1:0] step
);
  localparam int CNT_W = $clog2(RST_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(RST_HOLD - 1);

  logic             startPrev;
  logic [CNT_W-1:0] hiCnt;
  logic             softRst;
  logic             endInstr;
  logic             halt;
  logic [NSTEP-1:0] tDec;
  logic             isBranch;
  logic             condFlag;
  logic             taken;

  // decoded timing signals, one per step
  for (genvar gi = 0; gi < NSTEP; gi++) begin : g_tdec
    assign tDec[gi] = (step == STEP_W'(gi));
  end

  assign softRst  = resetReq && (hiCnt == HOLD_MAX);
  assign isBranch = (opcode[7:3] == 5'b00001);

  always_comb begin
    unique case (opcode[2:1])
      2'b00:   condFlag = flags[2]; // Z
      2'b01:   condFlag = flags[0]; // C
      2'b10:   condFlag = flags[3]; // S
      default: condFlag = flags[1]; // V
    endcase
  end
  assign taken = condFlag ^ opcode[0];

  always_comb begin
    ctl           = '0;
    endInstr      = 1'b0;
    halt          = 1'b0;
    ctl.clrAll    = softRst;
    ctl.hostWrite = hostWe && !busy;
    if (busy && !softRst) begin
      if (tDec[0]) begin
        ctl.drFromMem = 1'b1;
      end else if (tDec[1]) begin
        ctl.irLoad = 1'b1;
        ctl.pcInc  = 1'b1;
      end else if (isBranch || opcode == OP_JMPI) begin
        if (tDec[2]) ctl.drFromMem = 1'b1;
        else begin
          if (isBranch && !taken) ctl.pcInc = 1'b1;
          else                    ctl.pcLoadDr = 1'b1;
          endInstr = 1'b1;
        end
      end else begin
        unique case (opcode)
          OP_INA: begin
            ctl.acOp  = AC_INC;
            ctl.updZS = 1'b1;
            ctl.updCV = 1'b1;
            endInstr  = 1'b1;
          end
          OP_CMA: begin
            ctl.acOp  = AC_CMP;
            ctl.updZS = 1'b1;
            endInstr  = 1'b1;
          end
          OP_LDI, OP_ADI, OP_SUBI: begin
            if (tDec[2]) ctl.drFromMem = 1'b1;
            else begin
              if (opcode == OP_LDI)      ctl.acOp = AC_LOAD;
              else if (opcode == OP_ADI) ctl.acOp = AC_ADD;
              else                       ctl.acOp = AC_SUB;
              ctl.updZS = 1'b1;
              ctl.updCV = (opcode != OP_LDI);
              ctl.pcInc = 1'b1;
              endInstr  = 1'b1;
            end
          end
          OP_LDA, OP_STA: begin
            if (tDec[2]) ctl.drFromMem = 1'b1;
            else if (tDec[3]) begin
              ctl.arLoad = 1'b1;
              ctl.pcInc  = 1'b1;
            end else if (tDec[4]) begin
              ctl.addrFromAr = 1'b1;
              if (opcode == OP_LDA) ctl.drFromMem = 1'b1;
              else begin
                ctl.memStore = 1'b1;
                endInstr     = 1'b1;
              end
            end else if (tDec[5]) begin
              ctl.acOp = AC_LOAD;
              endInstr = 1'b1;
            end
          end
          OP_JMPE: begin
            ctl.pcLoadExt = 1'b1;
            endInstr      = 1'b1;
          end
          default: halt = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      step      <= '0;
      startPrev <= 1'b0;
      hiCnt     <= '0;
    end else begin
      startPrev <= startIn;
      if (!resetReq)             hiCnt <= '0;
      else if (hiCnt != HOLD_MAX) hiCnt <= hiCnt + 1'b1;
      if (softRst) begin
        busy <= 1'b0;
        step <= '0;
      end else if (!busy) begin
        step <= '0;
        if (startIn && !startPrev) busy <= 1'b1;
      end else if (halt) begin
        busy <= 1'b0;
        step <= '0;
      end else if (endInstr) begin
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/accu_dpath.sv
module accu_dpath
  import accu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostData,
  input  logic [AW-1:0] extAddr,
  output logic [DW-1:0] opcode,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ac,
  output logic [3:0]    flags
);
  localparam int DEPTH = 1 << AW;
  localparam int MSB   = DW - 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ar;
  logic [DW-1:0] dr, ir;
  logic          sFlag, zFlag, vFlag, cFlag;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData;
  logic [DW-1:0] opB;
  logic          cin;
  logic [DW:0]   sumW;
  logic [DW-1:0] aluRes;
  logic          ovf;

  assign rdAddr = ctl.addrFromAr ? ar : pc;
  assign rdData = mem[rdAddr];

  always_comb begin
    opB = '0;
    cin = 1'b0;
    unique case (ctl.acOp)
      AC_INC:  cin = 1'b1;
      AC_ADD:  opB = dr;
      AC_SUB:  begin opB = ~dr; cin = 1'b1; end
      default: ;
    endcase
    sumW = {1'b0, ac} + {1'b0, opB} + {{DW{1'b0}}, cin};
    unique case (ctl.acOp)
      AC_INC, AC_ADD, AC_SUB: aluRes = sumW[DW-1:0];
      AC_CMP:                 aluRes = ~ac;
      AC_LOAD:                aluRes = dr;
      default:                aluRes = ac;
    endcase
    ovf = (ac[MSB] == opB[MSB]) && (aluRes[MSB] != ac[MSB]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0; ar <= '0; dr <= '0; ir <= '0; ac <= '0;
      sFlag <= 1'b0; zFlag <= 1'b0; vFlag <= 1'b0; cFlag <= 1'b0;
    end else if (ctl.clrAll) begin
      pc <= '0; ar <= '0; dr <= '0; ir <= '0; ac <= '0;
      sFlag <= 1'b0; zFlag <= 1'b0; vFlag <= 1'b0; cFlag <= 1'b0;
    end else begin
      if (ctl.drFromMem) dr <= rdData;
      if (ctl.irLoad)    ir <= dr;
      if (ctl.arLoad)    ar <= dr[AW-1:0];
      if (ctl.pcLoadExt)     pc <= extAddr;
      else if (ctl.pcLoadDr) pc <= dr[AW-1:0];
      else if (ctl.pcInc)    pc <= pc + 1'b1;
      if (ctl.acOp != AC_HOLD) ac <= aluRes;
      if (ctl.updZS) begin
        zFlag <= (aluRes == '0);
        sFlag <= aluRes[MSB];
      end
      if (ctl.updCV) begin
        cFlag <= sumW[DW];
        vFlag <= ovf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.memStore)       mem[ar]       <= ac;
    else if (ctl.hostWrite) mem[hostAddr] <= hostData;
  end

  assign opcode = ir;
  assign flags  = {sFlag, zFlag, vFlag, cFlag};
endmodule

// File: rtl/accu_core.sv
module accu_core
  import accu_pkg::*;
#(
  parameter int DATA_W = accu_pkg::DATA_W,
  parameter int ADDR_W = accu_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              resetReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic [ADDR_W-1:0] extAddr,
  output logic              busy,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] acOut,
  output logic [3:0]        flagsOut
);
  ctl_t              ctl;
  logic [STEP_W-1:0] step;
  logic [DATA_W-1:0] opcode;

  accu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .resetReq(resetReq),
    .hostWe(hostWe), .opcode(opcode[7:0]), .flags(flagsOut),
    .ctl(ctl), .busy(busy), .step(step)
  );

  accu_dpath #(.DW(DATA_W), .AW(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostAddr(hostAddr),
    .hostData(hostData), .extAddr(extAddr), .opcode(opcode),
    .pc(pcOut), .ac(acOut), .flags(flagsOut)
  );
endmodule

// File: rtl/accu_core_chk.sv
module accu_core_chk
  import accu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              resetReq,
  input logic              busy,
  input logic [AW-1:0]     pcOut,
  input logic [DW-1:0]     acOut,
  input logic [3:0]        flagsOut,
  input logic              clrAll,
  input logic [2:0]        pcSel,
  input logic [STEP_W-1:0] step
);
  // R1
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> (pcOut == '0 && acOut == '0 && flagsOut == '0 && !busy));

  // R2
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |-> ($past(resetReq) && $past(resetReq, 2)));

  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startIn));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busy) && !$past(clrAll)) |->
      ($stable(acOut) && $stable(flagsOut) && $stable(pcOut)));

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(step) < NSTEP));

  // R4
  idle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (step == '0));

  // R8
  pc_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pcSel));

  // R10
  halt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (step == '0));
endmodule

bind accu_core accu_core_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .resetReq(resetReq),
  .busy(busy), .pcOut(pcOut), .acOut(acOut), .flagsOut(flagsOut),
  .clrAll(ctl.clrAll), .pcSel({ctl.pcInc, ctl.pcLoadDr, ctl.pcLoadExt}),
  .step(step)
);

// File: tb/accu_core_bench.sv
module accu_core_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic       resetReq = 1'b0;
  logic       hostWe = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [7:0] hostData = '0;
  logic [7:0] extAddr = '0;
  logic       busy;
  logic [7:0] pcOut, acOut;
  logic [3:0] flagsOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] pc;
    logic [7:0] ac;
    logic [3:0] fl;
    int         cyc;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  accu_core u_accu_core (
    .clk(clk), .rstN(rstN), .startIn(startIn), .resetReq(resetReq),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .extAddr(extAddr), .busy(busy), .pcOut(pcOut), .acOut(acOut),
    .flagsOut(flagsOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    hostWe = 1'b1; hostAddr = a; hostData = d;
    tick(1);
    hostWe = 1'b0;
  endtask

  // monitor: on each halt, pop the expected item and compare
  int  busyCyc = 0;
  logic prevBusy = 1'b0;
  always @(negedge clk) begin
    if (busy) busyCyc++;
    else if (prevBusy) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected halt act=1 exp=0");
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk({it.tag, " pc"}, int'(pcOut), int'(it.pc));
        chk({it.tag, " ac"}, int'(acOut), int'(it.ac));
        chk({it.tag, " flags"}, int'(flagsOut), int'(it.fl));
        if (it.cyc >= 0) chk({it.tag, " R4 busy cycles"}, busyCyc, it.cyc);
      end
      busyCyc = 0;
    end
    prevBusy = busy;
  end

  // driver: soft reset, queue expectation, start, wait for halt
  task automatic runProg(input string tag, input logic [7:0] ePc,
                         input logic [7:0] eAc, input logic [3:0] eFl,
                         input int eCyc, input bit midWr = 1'b0,
                         input logic [7:0] mA = 8'h00, input logic [7:0] mD = 8'h00);
    item_t it;
    resetReq = 1'b1; tick(3); resetReq = 1'b0; tick(1);
    it.pc = ePc; it.ac = eAc; it.fl = eFl; it.cyc = eCyc; it.tag = tag;
    sbq.push_back(it);
    startIn = 1'b1;
    tick(1);
    if (midWr) wr(mA, mD);
    while (sbq.size() != 0) tick(1);
    tick(3);
    chk({tag, " R3 no restart while start held"}, int'(busy), 0);
    startIn = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 act=hung exp=halted");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(1);
    chk("R1 reset pc", int'(pcOut), 0);
    chk("R1 reset ac", int'(acOut), 0);
    chk("R1 reset flags", int'(flagsOut), 0);
    chk("R1 reset busy", int'(busy), 0);

    for (int a = 0; a < 256; a++) wr(8'(a), 8'h00);

    // R5 R6 R7: LDI 34, ADI 19, CMA, INA, ADI 53, STA FA, halt
    wr(8'd0, 8'h03); wr(8'd1, 8'h34); wr(8'd2, 8'h04); wr(8'd3, 8'h19);
    wr(8'd4, 8'h02); wr(8'd5, 8'h01); wr(8'd6, 8'h04); wr(8'd7, 8'h53);
    wr(8'd8, 8'h07); wr(8'd9, 8'hFA); wr(8'd10, 8'h00);
    runProg("R5 R7 mixed arithmetic with store", 8'h0B, 8'h06, 4'b0001, 26);

    // R2: two-edge pulse ignored, three-edge pulse clears
    resetReq = 1'b1; tick(2); resetReq = 1'b0; tick(1);
    chk("R2 short pulse keeps ac", int'(acOut), 8'h06);
    chk("R2 short pulse keeps pc", int'(pcOut), 8'h0B);
    resetReq = 1'b1; tick(3); resetReq = 1'b0; tick(1);
    chk("R2 R1 held reset ac", int'(acOut), 0);
    chk("R2 R1 held reset pc", int'(pcOut), 0);
    chk("R2 R1 held reset flags", int'(flagsOut), 0);

    // R7: LDA reads stored byte (store kept over reset R2), S stays set
    wr(8'd0, 8'h03); wr(8'd1, 8'h80); wr(8'd2, 8'h06); wr(8'd3, 8'hFA);
    wr(8'd4, 8'h00);
    runProg("R7 R2 load after store", 8'h05, 8'h06, 4'b1000, 13);

    // R5: INA signed overflow 7F -> 80
    wr(8'd0, 8'h03); wr(8'd1, 8'h7F); wr(8'd2, 8'h01); wr(8'd3, 8'h00);
    runProg("R5 INA overflow", 8'h04, 8'h80, 4'b1010, 10);

    // R5: SUBI equal -> zero, no borrow
    wr(8'd0, 8'h03); wr(8'd1, 8'h05); wr(8'd2, 8'h05); wr(8'd3, 8'h05);
    wr(8'd4, 8'h00);
    runProg("R5 SUBI zero", 8'h05, 8'h00, 4'b0101, 11);
    // R5: then borrow
    wr(8'd4, 8'h05); wr(8'd5, 8'h01); wr(8'd6, 8'h00);
    runProg("R5 SUBI borrow", 8'h07, 8'hFF, 4'b1000, 15);
    // R5: SUBI signed overflow 80-1
    wr(8'd0, 8'h03); wr(8'd1, 8'h80); wr(8'd2, 8'h05); wr(8'd3, 8'h01);
    wr(8'd4, 8'h00);
    runProg("R5 SUBI overflow", 8'h05, 8'h7F, 4'b0011, 11);

    // R6: ADI carry then CMA keeps C and V
    wr(8'd0, 8'h03); wr(8'd1, 8'hFF); wr(8'd2, 8'h04); wr(8'd3, 8'h01);
    wr(8'd4, 8'h02); wr(8'd5, 8'h00);
    runProg("R6 CMA keeps carry", 8'h06, 8'hFF, 4'b1001, 14);
    // R6: LDI 00 keeps C
    wr(8'd5, 8'h03); wr(8'd6, 8'h00); wr(8'd7, 8'h00);
    runProg("R6 LDI keeps carry", 8'h08, 8'h00, 4'b0101, 18);

    // R8: BZ taken and BNZ not taken
    wr(8'd0, 8'h03); wr(8'd1, 8'h00); wr(8'd2, 8'h08); wr(8'd3, 8'h10);
    wr(8'd4, 8'h03); wr(8'd5, 8'h22); wr(8'd6, 8'h00);
    wr(8'h10, 8'h03); wr(8'h11, 8'h11); wr(8'h12, 8'h00);
    runProg("R8 BZ taken", 8'h13, 8'h11, 4'b0000, 15);
    wr(8'd2, 8'h09);
    runProg("R8 BNZ not taken", 8'h07, 8'h22, 4'b0000, 15);

    // R8: every branch under two opposite flag sets
    for (int p = 0; p < 2; p++) begin
      for (int op = 8; op < 16; op++) begin
        logic [3:0] fl;
        logic       f;
        logic       tk;
        fl = (p == 0) ? 4'b1010 : 4'b0101; // {S,Z,V,C}
        case ((op >> 1) & 3)
          0:       f = fl[2];
          1:       f = fl[0];
          2:       f = fl[3];
          default: f = fl[1];
        endcase
        tk = f ^ op[0];
        wr(8'd0, 8'h03); wr(8'd1, (p == 0) ? 8'h7F : 8'hFF); wr(8'd2, 8'h01);
        wr(8'd3, 8'(op)); wr(8'd4, 8'h20); wr(8'd5, 8'h00); wr(8'h20, 8'h00);
        runProg($sformatf("R8 branch op %0h prelude %0d", op, p),
                tk ? 8'h21 : 8'h06, (p == 0) ? 8'h80 : 8'h00, fl, 14);
      end
    end

    // R9: JMPI and JMPE
    wr(8'd0, 8'h10); wr(8'd1, 8'h30); wr(8'h30, 8'h00);
    runProg("R9 JMPI", 8'h31, 8'h00, 4'b0000, 7);
    extAddr = 8'h40;
    wr(8'd0, 8'h11); wr(8'h40, 8'h00);
    runProg("R9 JMPE", 8'h41, 8'h00, 4'b0000, 6);

    // R10: undefined opcode FF halts
    wr(8'd0, 8'hFF);
    runProg("R10 undefined halt", 8'h01, 8'h00, 4'b0000, 3);

    // R11: write while busy is ignored
    wr(8'd0, 8'h03); wr(8'd1, 8'h55); wr(8'd2, 8'h00); wr(8'd3, 8'h00);
    runProg("R11 busy write ignored", 8'h03, 8'h55, 4'b0000, 7, 1'b1, 8'd2, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule